// File: doc/BRIEF.md
# Three-Axis Sample Buffer with Selectable Fill Policy

This block sits between a motion-sensor core and a register-mapped host port. It holds up to 32 sample sets, each an X, Y and Z value. The sensor core strobes `push_en` once per output-data-rate tick with a fresh set. The host strobes `pop_en` to take the oldest unread set, which appears on `pop_x`, `pop_y` and `pop_z` one cycle later.

A control byte sets the fill policy:

- **Pass-through:** nothing is kept.
- **Halt-when-full:** a full buffer refuses new sets.
- **Ring:** a full buffer drops its oldest set to make room.
- **Armed ring:** ring behaviour until a chosen trigger input is seen, then halt-when-full.

The control byte also carries the trigger choice and a watermark level. A packed status byte reports four things:

- the watermark flag;
- a full/overrun flag, which clears as soon as one set is taken;
- an empty flag;
- the unread count.

Top module: `triax_sample_fifo`

## Requirements
- R1: After reset the status byte reads 0x20 (empty), the unread count is zero and the three read outputs are zero.
- R2: The control byte decodes as follows: bits [7:6] pick the policy (00 pass-through, 01 halt-when-full, 10 ring, 11 armed ring); bit 5 picks the trigger for armed ring (0 = `trig_a`, 1 = `trig_b`); bits [4:0] give the watermark level.
- R3: While the policy is pass-through, pushes are ignored and the count stays at zero. Entering pass-through discards all stored sets and clears the armed-ring freeze latch, so the status byte reads 0x20 on the cycle after pass-through is seen at a clock edge.
- R4: Sets come out in the order they were accepted. The set taken by a pop with at least one stored set appears on the read outputs in the cycle after that pop's clock edge.
- R5: In halt-when-full, a push to a buffer holding 32 sets with no pop in the same cycle is ignored and the stored contents are unchanged.
- R6: In ring mode, a push to a full buffer with no pop discards the oldest set and stores the new one, and the count stays at 32.
- R7: Armed ring behaves as ring until the selected trigger is high at a clock edge; from the next edge it behaves as halt-when-full. The unselected trigger has no effect.
- R8: The status byte is laid out as follows, and it reflects the stored count one cycle after the push or pop edge:
  - bit 7: the count is strictly greater than the watermark level;
  - bit 6: 32 unread sets are stored;
  - bit 5: no unread sets are stored;
  - bits [4:0]: the count modulo 32, so a full buffer reads 0 here.
- R9: The overrun flag clears on the cycle after the first pop from a full buffer.
- R10: A push and a pop in the same cycle on a non-empty buffer leave the count unchanged and perform both the store and the retrieval.
- R11: A pop with nothing stored leaves the read outputs at their previous value and the count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ctrl_byte | input | 8 | Policy, trigger select and watermark level |
| push_en | input | 1 | New sample set strobe from the sensor core |
| push_x | input | SAMPLE_W | X value of the pushed set |
| push_y | input | SAMPLE_W | Y value of the pushed set |
| push_z | input | SAMPLE_W | Z value of the pushed set |
| pop_en | input | 1 | Host retrieval strobe |
| trig_a | input | 1 | First freeze trigger source |
| trig_b | input | 1 | Second freeze trigger source |
| pop_x | output | SAMPLE_W | X value of the last retrieved set |
| pop_y | output | SAMPLE_W | Y value of the last retrieved set |
| pop_z | output | SAMPLE_W | Z value of the last retrieved set |
| status_byte | output | 8 | Watermark, overrun, empty and unread count |

## Verification
The status byte mirrors the count on the cycle after each edge. A count that drifts from the true number of stored sets therefore shows up at once, through a wrong count field, a wrong empty or overrun flag, or a watermark flag flipping at the wrong fill.

Read and write pointers that slip relative to each other stay hidden until a pop. At that point the read outputs show a set out of order one cycle later.

A wrong freeze latch or overwrite decision only becomes visible on the next pop after the buffer has filled. At that pop, the oldest set returned differs from the one a reference queue predicts.

// File: rtl/triax_fifo_pkg.sv
package triax_fifo_pkg;

    parameter int unsigned FIFO_DEPTH = 32;
    localparam int unsigned PTR_W     = $clog2(FIFO_DEPTH);
    localparam int unsigned CNT_W     = PTR_W + 1;
    localparam int unsigned LVL_W     = 5;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_HALT  = 2'b01,
        MODE_RING  = 2'b10,
        MODE_ARMED = 2'b11
    } fifo_mode_e;

    typedef struct packed {
        fifo_mode_e       mode;
        logic             trig_sel;
        logic [LVL_W-1:0] wm_level;
    } fifo_ctrl_t;

endpackage

// File: rtl/triax_ctrl_decode.sv
module triax_ctrl_decode
    import triax_fifo_pkg::*;
(
    input  logic [7:0] ctrl_byte,
    output fifo_ctrl_t ctrl
);

    // policy in the top two bits, trigger choice below, level in the low field
    always_comb begin
        ctrl.mode     = fifo_mode_e'(ctrl_byte[7:6]);
        ctrl.trig_sel = ctrl_byte[5];
        ctrl.wm_level = ctrl_byte[LVL_W-1:0];
    end

endmodule

// File: rtl/triax_status_pack.sv
module triax_status_pack
    import triax_fifo_pkg::*;
(
    input  logic [CNT_W-1:0] fill,
    input  logic [LVL_W-1:0] wm_level,
    output logic [7:0]       status_byte
);

    localparam int unsigned FIELD_W = 5;

    logic wm_hit;
    logic is_full;
    logic is_empty;

    always_comb begin
        wm_hit      = fill > CNT_W'(wm_level);
        is_full     = fill == CNT_W'(FIFO_DEPTH);
        is_empty    = fill == '0;
        status_byte = {wm_hit, is_full, is_empty, fill[FIELD_W-1:0]};
    end

endmodule

// File: rtl/triax_sample_ram.sv
module triax_sample_ram #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 48
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);

    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_addr];

endmodule

// File: rtl/triax_sample_fifo.sv
module triax_sample_fifo
    import triax_fifo_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          ctrl_byte,
    input  logic                push_en,
    input  logic [SAMPLE_W-1:0] push_x,
    input  logic [SAMPLE_W-1:0] push_y,
    input  logic [SAMPLE_W-1:0] push_z,
    input  logic                pop_en,
    input  logic                trig_a,
    input  logic                trig_b,
    output logic [SAMPLE_W-1:0] pop_x,
    output logic [SAMPLE_W-1:0] pop_y,
    output logic [SAMPLE_W-1:0] pop_z,
    output logic [7:0]          status_byte
);

    localparam int unsigned SET_W = 3 * SAMPLE_W;

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] fill;
        logic             frozen;
        logic [SET_W-1:0] rd_set;
    } state_t;

    state_t     state_d;
    state_t     state_q;
    fifo_ctrl_t ctl;
    logic [SET_W-1:0] head_set;
    logic       ram_we;
    logic       can_pop;
    logic       is_full;
    logic       stop_full;
    logic       overwrite;
    logic       sel_trig;

    triax_ctrl_decode i_decode (
        .ctrl_byte (ctrl_byte),
        .ctrl      (ctl)
    );

    triax_sample_ram #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (SET_W)
    ) i_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (state_q.wr_ptr),
        .wr_data ({push_x, push_y, push_z}),
        .rd_addr (state_q.rd_ptr),
        .rd_data (head_set)
    );

    triax_status_pack i_status (
        .fill        (state_q.fill),
        .wm_level    (ctl.wm_level),
        .status_byte (status_byte)
    );

    always_comb begin
        state_d   = state_q;
        ram_we    = 1'b0;
        overwrite = 1'b0;
        stop_full = 1'b0;
        can_pop   = pop_en && (state_q.fill != '0);
        is_full   = state_q.fill == CNT_W'(FIFO_DEPTH);
        sel_trig  = ctl.trig_sel ? trig_b : trig_a;

        if (ctl.mode == MODE_PASS) begin
            // flush: pointers, count and freeze latch back to idle
            state_d.wr_ptr = '0;
            state_d.rd_ptr = '0;
            state_d.fill   = '0;
            state_d.frozen = 1'b0;
        end else begin
            stop_full = (ctl.mode == MODE_HALT) ||
                        ((ctl.mode == MODE_ARMED) && state_q.frozen);
            ram_we    = push_en && (!is_full || can_pop || !stop_full);
            overwrite = push_en && is_full && !can_pop && !stop_full;

            if (can_pop) begin
                state_d.rd_set = head_set;
            end
            if (can_pop || overwrite) begin
                state_d.rd_ptr = state_q.rd_ptr + 1'b1;
            end
            if (ram_we) begin
                state_d.wr_ptr = state_q.wr_ptr + 1'b1;
            end
            if (ram_we && !overwrite && !can_pop) begin
                state_d.fill = state_q.fill + 1'b1;
            end else if (can_pop && !ram_we) begin
                state_d.fill = state_q.fill - 1'b1;
            end
            if ((ctl.mode == MODE_ARMED) && sel_trig) begin
                state_d.frozen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign {pop_x, pop_y, pop_z} = state_q.rd_set;

endmodule

// File: rtl/triax_sample_fifo_chk.sv
module triax_sample_fifo_chk #(
    parameter int unsigned SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          ctrl_byte,
    input logic                push_en,
    input logic                pop_en,
    input logic [SAMPLE_W-1:0] pop_x,
    input logic [7:0]          status_byte
);

    AST_PASS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_byte[7:6] == 2'b00) |=> (status_byte == 8'h20)); // R3

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_byte[6] && status_byte[5])); // R8

    AST_EMPTY_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5] |-> (status_byte[4:0] == 5'd0)); // R8

    AST_DRY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[5] && pop_en) |=> $stable(pop_x)); // R11

    AST_HALT_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_byte[7:6] == 2'b01) && status_byte[6] && push_en && !pop_en)
        |=> (status_byte[6] && status_byte[4:0] == 5'd0)); // R5

    AST_PAIR_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_byte[7:6] != 2'b00) && !status_byte[5] && push_en && pop_en)
        |=> $stable(status_byte[6:0])); // R10

endmodule

bind triax_sample_fifo triax_sample_fifo_chk #(
    .SAMPLE_W (SAMPLE_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_byte   (ctrl_byte),
    .push_en     (push_en),
    .pop_en      (pop_en),
    .pop_x       (pop_x),
    .status_byte (status_byte)
);

// File: tb/test_triax_sample_fifo.sv
module test_triax_sample_fifo;

    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    ctrl_byte;
    logic          push_en;
    logic [SW-1:0] push_x;
    logic [SW-1:0] push_y;
    logic [SW-1:0] push_z;
    logic          pop_en;
    logic          trig_a;
    logic          trig_b;
    logic [SW-1:0] pop_x;
    logic [SW-1:0] pop_y;
    logic [SW-1:0] pop_z;
    logic [7:0]    status_byte;

    always #5 clk = ~clk;

    triax_sample_fifo #(.SAMPLE_W(SW)) i_triax_sample_fifo (
        .clk (clk), .rst_n (rst_n), .ctrl_byte (ctrl_byte),
        .push_en (push_en), .push_x (push_x), .push_y (push_y), .push_z (push_z),
        .pop_en (pop_en), .trig_a (trig_a), .trig_b (trig_b),
        .pop_x (pop_x), .pop_y (pop_y), .pop_z (pop_z),
        .status_byte (status_byte)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [3*SW-1:0] q[$];
    logic [3*SW-1:0] last_rd;
    bit              frz;
    string           tag;
    int unsigned     seq;

    function automatic logic [7:0] exp_status(logic [7:0] c);
        int n = q.size();
        return {(n > int'(c[4:0])), (n == 32), (n == 0), n[4:0]};
    endfunction

    task automatic check8(string t, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s status act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic check48(string t, logic [3*SW-1:0] act, logic [3*SW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s read act=%h exp=%h", t, act, exp);
        end
    endtask

    // reference model step, applied with the inputs of one clock edge
    task automatic model_step(bit p, bit r, bit ta, bit tb, logic [3*SW-1:0] d);
        bit stop;
        if (ctrl_byte[7:6] == 2'b00) begin
            q.delete();
            frz = 0;
        end else begin
            stop = (ctrl_byte[7:6] == 2'b01) || (ctrl_byte[7:6] == 2'b11 && frz);
            if (r && q.size() > 0) last_rd = q.pop_front();
            if (p) begin
                if (q.size() < 32) q.push_back(d);
                else if (!stop) begin
                    void'(q.pop_front());
                    q.push_back(d);
                end
            end
            if (ctrl_byte[7:6] == 2'b11 && (ctrl_byte[5] ? tb : ta)) frz = 1;
        end
    endtask

    task automatic cyc(bit p, bit r, bit ta = 0, bit tb = 0);
        logic [3*SW-1:0] d;
        push_en = p; pop_en = r; trig_a = ta; trig_b = tb;
        push_x = seq[SW-1:0];
        push_y = seq[SW-1:0] ^ 16'hA5A5;
        push_z = seq[SW-1:0] + 16'd1000;
        d = {push_x, push_y, push_z};
        @(posedge clk);
        model_step(p, r, ta, tb, d);
        if (p) seq++;
        @(negedge clk);
        check8(tag, status_byte, exp_status(ctrl_byte));
        check48(tag, {pop_x, pop_y, pop_z}, last_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 0; ctrl_byte = 8'h00; push_en = 0; pop_en = 0;
        trig_a = 0; trig_b = 0; push_x = '0; push_y = '0; push_z = '0;
        seq = 1; last_rd = '0; frz = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check8("R1", status_byte, 8'h20);
        check48("R1", {pop_x, pop_y, pop_z}, '0);

        // R2 / R4: halt policy, watermark level 2, ordered retrieval
        tag = "R4"; ctrl_byte = 8'h42;
        for (int i = 0; i < 5; i++) cyc(1, 0);
        tag = "R2";
        for (int i = 0; i < 5; i++) cyc(0, 1);

        // R11: pop while empty
        tag = "R11";
        cyc(0, 1); cyc(0, 1);

        // R5 / R8: overfill in halt mode
        tag = "R5"; ctrl_byte = 8'h5F;
        for (int i = 0; i < 36; i++) cyc(1, 0);
        // R9: one pop clears overrun
        tag = "R9"; cyc(0, 1);
        // R10: paired push and pop
        tag = "R10";
        for (int i = 0; i < 4; i++) cyc(1, 1);
        tag = "R5";
        for (int i = 0; i < 32; i++) cyc(0, 1);

        // R6: ring overwrite
        tag = "R6"; ctrl_byte = 8'h90;
        for (int i = 0; i < 40; i++) cyc(1, 0);
        tag = "R10"; cyc(1, 1);
        tag = "R6";
        for (int i = 0; i < 33; i++) cyc(0, 1);

        // R3: flush on pass-through, pushes ignored
        tag = "R3"; ctrl_byte = 8'h80;
        for (int i = 0; i < 6; i++) cyc(1, 0);
        ctrl_byte = 8'h00;
        for (int i = 0; i < 4; i++) cyc(1, 0);
        ctrl_byte = 8'h80;
        cyc(0, 1); cyc(0, 1);

        // R7: armed ring on trig_b, trig_a must be ignored
        tag = "R7"; ctrl_byte = 8'hE4;
        for (int i = 0; i < 36; i++) cyc(1, 0, i[0], 0);
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0);
        for (int i = 0; i < 33; i++) cyc(0, 1);
        // R3: pass-through clears freeze, then armed ring on trig_a
        ctrl_byte = 8'h00; cyc(0, 0);
        ctrl_byte = 8'hC3;
        for (int i = 0; i < 34; i++) cyc(1, 0, 0, 1);
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0);
        for (int i = 0; i < 33; i++) cyc(0, 1);

        // R8: constrained random mix
        tag = "R8";
        for (int blk = 0; blk < 60; blk++) begin
            ctrl_byte = 8'($urandom);
            if (($urandom % 8) != 0 && ctrl_byte[7:6] == 2'b00) ctrl_byte[7:6] = 2'b10;
            for (int i = 0; i < 50; i++) begin
                cyc(($urandom % 10) < 6, ($urandom % 10) < 4,
                    ($urandom % 40) == 0, ($urandom % 40) == 0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule